// File: doc/BRIEF.md
# Quadword Load/Store Sequencer

This block moves a 128-bit register value to or from memory over a 64-bit memory port. A request carries a base address, a signed 16-bit displacement, a direction flag, a destination register index and, for stores, the 128-bit value. The block forms the effective address and clears its low four bits, so every transfer lands on a 16-byte boundary and never faults on misalignment. It then runs two memory beats, one after the other.

The first beat always carries the less significant 64 bits at the aligned address. The second beat carries the more significant 64 bits, eight bytes higher. Store beats complete when the memory accepts the request; no response is expected for them. Load beats complete when the memory returns data. The two returned words are then offered to the register file as one 128-bit value, together with a single-cycle write strobe. Index zero names a register that is never written.

The requester side uses a valid/ready handshake. The memory side has a request channel with valid/ready and a response channel that carries only valid.

Top module: `qword_mover`

## Requirements
- R1: The first beat's address equals (req_base + sign-extended req_ofs) with bits [3:0] forced to zero.
- R2: The second beat's address equals the first beat's address plus 8.
- R3: For a store (req_store = 1), mem_req_write is 1 on both beats; the first beat carries req_wdata[63:0] and the second carries req_wdata[127:64].
- R4: For a load (req_store = 0), rf_wdata[63:0] holds the first response word and rf_wdata[127:64] holds the second. rf_idx equals the requested destination index while rf_we is high.
- R5: For a load with a non-zero destination, rf_we is high for exactly one cycle: the cycle after the clock edge that accepts the second response. rf_we never rises for a store.
- R6: A load whose destination index is 0 completes both beats but never raises rf_we.
- R7: After reset, req_ready is 1 and busy, mem_req_valid and rf_we are 0. req_ready is high only when busy is low. busy is high from the edge that accepts a request through the final cycle of the transfer. req_valid has no effect while busy is high.
- R8: mem_req_valid is high only while a beat is waiting to be accepted, and it holds address and data steady until mem_req_ready is seen. The second beat is not requested until the first beat is complete: accepted for a store, answered for a load.
- R9: The displacement is treated as signed, so negative values lower the address, including values that cross below the base's 16-byte block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken (idle) |
| req_base | input | AW | Base address |
| req_ofs | input | OFS_W | Signed displacement |
| req_store | input | 1 | 1 = store, 0 = load |
| req_dst | input | IDX_W | Destination register index for loads |
| req_wdata | input | 2*DW | Store value |
| busy | output | 1 | Transfer in progress |
| mem_req_valid | output | 1 | Memory beat request |
| mem_req_ready | input | 1 | Memory accepts the beat |
| mem_req_addr | output | AW | Beat address |
| mem_req_write | output | 1 | Beat is a write |
| mem_req_wdata | output | DW | Beat write data |
| mem_rsp_valid | input | 1 | Load data returned |
| mem_rsp_data | input | DW | Returned load word |
| rf_we | output | 1 | Register write strobe |
| rf_idx | output | IDX_W | Register index to write |
| rf_wdata | output | 2*DW | Assembled load value |

## Verification
Two things can fall in the same cycle: the end of one transfer and a new request. That end is the write-back strobe for a load, or the final cycle for a store. The bench keeps req_valid high with junk fields on alternate cycles while the block is busy, including the write-back cycle, and presents the next real request the moment the model expects idle. The per-cycle model then judges several things together: whether req_ready, busy and rf_we agree, whether any junk leaked into a later beat address, and whether the strobe landed in the right cycle. Memory stalls and response latencies vary with the cycle count, so both the request-hold path and the wait-for-response path meet these boundaries.

// File: rtl/qw_pkg.sv
package qw_pkg;
   typedef enum logic [1:0] {
      QW_IDLE = 2'd0,
      QW_LO   = 2'd1,
      QW_HI   = 2'd2,
      QW_FIN  = 2'd3
   } qw_state_e;
endpackage

// File: rtl/qw_addr_gen.sv
module qw_addr_gen #(
   parameter int AW    = 32,
   parameter int OFS_W = 16,
   parameter int DW    = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [AW-1:0]    base,
   input  logic [OFS_W-1:0] ofs,
   output logic [AW-1:0]    lo_addr,
   output logic [AW-1:0]    hi_addr
);
   localparam int STEP  = DW / 8;
   localparam int LOW_B = $clog2(2 * STEP);

   logic [AW-1:0] ofs_ext;
   logic [AW-1:0] sum;
   logic [AW-1:0] aligned;
   logic [AW-1:0] lo_q;

   generate
      if (AW < OFS_W) begin : g_bad_width
         $error("qw_addr_gen: AW must be at least OFS_W");
      end
      if (AW > OFS_W) begin : g_sext
         assign ofs_ext = {{(AW-OFS_W){ofs[OFS_W-1]}}, ofs};
      end else begin : g_same
         assign ofs_ext = ofs[AW-1:0];
      end
   endgenerate

   assign sum     = base + ofs_ext;
   assign aligned = {sum[AW-1:LOW_B], {LOW_B{1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    lo_q <= '0;
      else if (load) lo_q <= aligned;
   end

   assign lo_addr = lo_q;
   assign hi_addr = lo_q + AW'(STEP);
endmodule

// File: rtl/qw_seq.sv
module qw_seq
   import qw_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start,
   input  logic      is_store,
   input  logic      mem_ready,
   input  logic      rsp_valid,
   output qw_state_e state,
   output logic      issue,
   output logic      beat_hi,
   output logic [1:0] cap
);
   qw_state_e st_q, st_d;
   logic      pend_q, pend_d;

   always_comb begin
      st_d   = st_q;
      pend_d = pend_q;
      unique case (st_q)
         QW_IDLE: if (start) begin
            st_d   = QW_LO;
            pend_d = 1'b0;
         end
         QW_LO, QW_HI: begin
            if (!pend_q) begin
               if (mem_ready) begin
                  if (is_store) st_d = (st_q == QW_LO) ? QW_HI : QW_FIN;
                  else          pend_d = 1'b1;
               end
            end else if (rsp_valid) begin
               pend_d = 1'b0;
               st_d   = (st_q == QW_LO) ? QW_HI : QW_FIN;
            end
         end
         QW_FIN: st_d = QW_IDLE;
         default: st_d = QW_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= QW_IDLE;
         pend_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         pend_q <= pend_d;
      end
   end

   assign state   = st_q;
   assign issue   = ((st_q == QW_LO) || (st_q == QW_HI)) && !pend_q;
   assign beat_hi = (st_q == QW_HI);
   assign cap[0]  = pend_q && rsp_valid && (st_q == QW_LO);
   assign cap[1]  = pend_q && rsp_valid && (st_q == QW_HI);
endmodule

// File: rtl/qw_capture.sv
module qw_capture #(
   parameter int DW    = 64,
   parameter int IDX_W = 5,
   parameter int BEATS = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic                store_in,
   input  logic [IDX_W-1:0]    dst_in,
   input  logic [BEATS*DW-1:0] wdata_in,
   input  logic                beat_sel,
   input  logic [BEATS-1:0]    cap,
   input  logic [DW-1:0]       rsp_data,
   output logic                store_q,
   output logic [IDX_W-1:0]    dst_q,
   output logic [DW-1:0]       beat_wdata,
   output logic [BEATS*DW-1:0] rdata
);
   logic [BEATS*DW-1:0] wdata_q;

   generate
      if (BEATS != 2) begin : g_bad_beats
         $error("qw_capture: exactly two beats are supported");
      end
      for (genvar b = 0; b < BEATS; b++) begin : g_beat
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      rdata[b*DW +: DW] <= '0;
            else if (cap[b]) rdata[b*DW +: DW] <= rsp_data;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         store_q <= 1'b0;
         dst_q   <= '0;
         wdata_q <= '0;
      end else if (load) begin
         store_q <= store_in;
         dst_q   <= dst_in;
         wdata_q <= wdata_in;
      end
   end

   assign beat_wdata = beat_sel ? wdata_q[DW +: DW] : wdata_q[0 +: DW];
endmodule

// File: rtl/qword_mover.sv
module qword_mover
   import qw_pkg::*;
#(
   parameter int AW    = 32,
   parameter int DW    = 64,
   parameter int OFS_W = 16,
   parameter int IDX_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [AW-1:0]     req_base,
   input  logic [OFS_W-1:0]  req_ofs,
   input  logic              req_store,
   input  logic [IDX_W-1:0]  req_dst,
   input  logic [2*DW-1:0]   req_wdata,
   output logic              busy,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [AW-1:0]     mem_req_addr,
   output logic              mem_req_write,
   output logic [DW-1:0]     mem_req_wdata,
   input  logic              mem_rsp_valid,
   input  logic [DW-1:0]     mem_rsp_data,
   output logic              rf_we,
   output logic [IDX_W-1:0]  rf_idx,
   output logic [2*DW-1:0]   rf_wdata
);
   localparam int BEATS = 2;

   generate
      if (DW % 8 != 0) begin : g_bad_dw
         $error("qword_mover: DW must be a whole number of bytes");
      end
   endgenerate

   qw_state_e        state;
   logic             issue, beat_hi, accept, store_q;
   logic [BEATS-1:0] cap;
   logic [AW-1:0]    lo_addr, hi_addr;
   logic [IDX_W-1:0] dst_q;

   assign req_ready = (state == QW_IDLE);
   assign accept    = req_valid && req_ready;
   assign busy      = !req_ready;

   qw_addr_gen #(.AW(AW), .OFS_W(OFS_W), .DW(DW)) u_addr (
      .clk(clk), .rst_n(rst_n), .load(accept),
      .base(req_base), .ofs(req_ofs),
      .lo_addr(lo_addr), .hi_addr(hi_addr)
   );

   qw_seq u_seq (
      .clk(clk), .rst_n(rst_n), .start(accept), .is_store(store_q),
      .mem_ready(mem_req_ready), .rsp_valid(mem_rsp_valid),
      .state(state), .issue(issue), .beat_hi(beat_hi), .cap(cap)
   );

   qw_capture #(.DW(DW), .IDX_W(IDX_W), .BEATS(BEATS)) u_cap (
      .clk(clk), .rst_n(rst_n), .load(accept),
      .store_in(req_store), .dst_in(req_dst), .wdata_in(req_wdata),
      .beat_sel(beat_hi), .cap(cap), .rsp_data(mem_rsp_data),
      .store_q(store_q), .dst_q(dst_q),
      .beat_wdata(mem_req_wdata), .rdata(rf_wdata)
   );

   assign mem_req_valid = issue;
   assign mem_req_addr  = beat_hi ? hi_addr : lo_addr;
   assign mem_req_write = store_q;
   assign rf_we         = (state == QW_FIN) && !store_q && (dst_q != '0);
   assign rf_idx        = dst_q;
endmodule

// File: rtl/qword_mover_chk.sv
module qword_mover_chk #(
   parameter int AW    = 32,
   parameter int DW    = 64,
   parameter int IDX_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic             busy,
   input logic             mem_req_valid,
   input logic             mem_req_ready,
   input logic [AW-1:0]    mem_req_addr,
   input logic [DW-1:0]    mem_req_wdata,
   input logic             rf_we,
   input logic [IDX_W-1:0] rf_idx
);
   p_ready_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !busy);

   p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> busy);

   p_we_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |=> !rf_we);

   p_we_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> (rf_idx != '0));

   p_beat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=>
         (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_wdata)));

   p_beat_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));

   p_no_issue_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_req_valid);
endmodule

bind qword_mover qword_mover_chk #(.AW(AW), .DW(DW), .IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
   .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
   .rf_we(rf_we), .rf_idx(rf_idx)
);

// File: tb/test_qword_mover.sv
module test_qword_mover;
   localparam int AW = 32, DW = 64, OFS_W = 16, IDX_W = 5;
   localparam int NTX = 24;
   localparam int LIMIT = 20000;

   logic clk = 1'b0;
   logic rst_n;
   logic req_valid, req_ready, req_store, busy;
   logic [AW-1:0] req_base;
   logic [OFS_W-1:0] req_ofs;
   logic [IDX_W-1:0] req_dst;
   logic [2*DW-1:0] req_wdata;
   logic mem_req_valid, mem_req_ready, mem_req_write, mem_rsp_valid;
   logic [AW-1:0] mem_req_addr;
   logic [DW-1:0] mem_req_wdata, mem_rsp_data;
   logic rf_we;
   logic [IDX_W-1:0] rf_idx;
   logic [2*DW-1:0] rf_wdata;

   always #10 clk = ~clk;

   qword_mover #(.AW(AW), .DW(DW), .OFS_W(OFS_W), .IDX_W(IDX_W)) i_qword_mover (.*);

   int checks = 0, errors = 0;

   task automatic chk(input bit ok, input string tag, input logic [2*DW-1:0] act,
                      input logic [2*DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
      return {a ^ 32'hA55A_0F0F, a * 32'd3 + 32'd17};
   endfunction

   // reference model state
   int ms, k, lat, txn, done_cnt, cyc;
   logic          t_st;
   logic [IDX_W-1:0] t_dst;
   logic [2*DW-1:0]  t_wd;
   logic [AW-1:0]    t_al;
   bit               t_neg;
   logic [DW-1:0]    got_lo, got_hi;

   initial begin
      req_valid = 0; req_base = '0; req_ofs = '0; req_store = 0; req_dst = '0;
      req_wdata = '0; mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = '0;
      rst_n = 0;
      repeat (3) @(negedge clk);
      // reset state (R7)
      chk(req_ready === 1'b1, "R7 reset req_ready", req_ready, 1);
      chk(busy === 1'b0, "R7 reset busy", busy, 0);
      chk(mem_req_valid === 1'b0, "R7 reset mem_req_valid", mem_req_valid, 0);
      chk(rf_we === 1'b0, "R7 reset rf_we", rf_we, 0);
      rst_n = 1;
      ms = 0; k = 0; lat = 0; txn = 0; done_cnt = 0; cyc = 0;
      while (done_cnt < NTX && cyc < LIMIT) begin
         @(negedge clk);
         cyc++;
         // ---- compare outputs with model ----
         chk(req_ready === (ms == 0), "R7 req_ready", req_ready, (ms == 0));
         chk(busy === (ms != 0), "R7 busy", busy, (ms != 0));
         chk(mem_req_valid === (ms == 1), "R8 mem_req_valid", mem_req_valid, (ms == 1));
         if (ms == 1 && mem_req_valid === 1'b1) begin
            if (k == 0)
               chk(mem_req_addr === t_al, t_neg ? "R9 beat0 addr" : "R1 beat0 addr",
                   mem_req_addr, t_al);
            else
               chk(mem_req_addr === t_al + 32'd8, "R2 beat1 addr", mem_req_addr, t_al + 32'd8);
            chk(mem_req_write === t_st, "R3 write flag", mem_req_write, t_st);
            if (t_st)
               chk(mem_req_wdata === (k == 0 ? t_wd[63:0] : t_wd[127:64]), "R3 store data",
                   mem_req_wdata, (k == 0 ? t_wd[63:0] : t_wd[127:64]));
         end
         begin
            bit exp_we;
            exp_we = (ms == 3) && !t_st && (t_dst != 0);
            chk(rf_we === exp_we, (ms == 3 && !t_st && t_dst == 0) ? "R6 rf_we" : "R5 rf_we",
                rf_we, exp_we);
            if (exp_we) begin
               chk(rf_wdata === {got_hi, got_lo}, "R4 rf_wdata", rf_wdata, {got_hi, got_lo});
               chk(rf_idx === t_dst, "R4 rf_idx", rf_idx, t_dst);
            end
         end
         // ---- drive inputs for the next edge ----
         mem_req_ready = (((cyc * 7) + txn) % 3) != 0;
         mem_rsp_valid = 0;
         if (ms == 2) begin
            if (lat == 0) begin
               mem_rsp_valid = 1;
               mem_rsp_data  = mem_word(k == 0 ? t_al : t_al + 32'd8);
            end else lat--;
         end
         if (ms == 0 && txn < NTX) begin
            req_valid = 1;
            req_base  = 32'h1000_0000 + txn * 32'h0001_2347;
            req_ofs   = (txn % 3 == 0) ? OFS_W'(-37 * (txn + 1)) : OFS_W'(21 * txn + 5);
            req_store = txn[0];
            req_dst   = (txn % 4 == 2) ? '0 : IDX_W'(txn + 1);
            req_wdata = {32'hC0DE_0000 + txn, 32'h1111_0000 ^ txn,
                         32'h2222_0000 + txn * 5, 32'h3333_0000 ^ (txn * 9)};
         end else begin
            // junk while busy must be ignored (R7)
            req_valid = cyc[0];
            req_base  = 32'hDEAD_BEE7;
            req_ofs   = 16'h7FF3;
            req_store = ~t_st;
            req_dst   = 5'd31;
            req_wdata = {4{32'hBAD0_BAD0}};
         end
         // ---- advance model over the coming edge ----
         case (ms)
            0: if (req_valid) begin
               logic [AW-1:0] ea;
               ea    = req_base + {{(AW-OFS_W){req_ofs[OFS_W-1]}}, req_ofs};
               t_al  = ea & ~32'hF;
               t_neg = req_ofs[OFS_W-1];
               t_st  = req_store; t_dst = req_dst; t_wd = req_wdata;
               ms = 1; k = 0; txn++;
            end
            1: if (mem_req_ready) begin
               if (t_st) begin
                  if (k == 0) k = 1; else ms = 3;
               end else begin
                  ms = 2; lat = (cyc + k) % 3;
               end
            end
            2: if (mem_rsp_valid) begin
               if (k == 0) begin got_lo = mem_rsp_data; k = 1; ms = 1; end
               else begin got_hi = mem_rsp_data; ms = 3; end
            end
            default: begin ms = 0; done_cnt++; end
         endcase
      end
      if (cyc >= LIMIT) begin
         checks++; errors++;
         $display("FAIL watchdog R8 actual=%0d expected=%0d transfers", done_cnt, NTX);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule